// File: doc/BRIEF.md
# PHY Strap-to-Register Configuration Controller

This block turns the configuration strap pins of a four-port 10/100 Ethernet transceiver into the per-port control register bits that set speed, duplex, auto-negotiation enable and fiber mode. It also holds the management register file that a serial management frame decoder reads and writes. In this project a plain address/data port stands in for that decoder. Every strap pin passes through a two-stage synchronizer before any logic uses it.

A synchronized mode-select pin chooses between two regimes. In management control (mode pin low), the strap pins are decoded once after reset and preloaded as register defaults. From then on only management writes change the registers. In manual control (mode pin high), management writes are discarded and the strap fields of every port are re-decoded from the pins on every cycle. A high per-port fiber-select pin always takes precedence over the global twisted-pair pins for that port. The access port has no back-pressure. A write is taken in the cycle its strobe is high. A read request is always accepted and its answer appears, flagged valid, exactly one cycle later. The requester must be able to take that answer and cannot stall it.

Top module: `phy_strap_ctrl`

## Requirements
- R1: While reset is asserted, all per-port outputs are 0 and `rd_valid` is 0.
- R2: With the mode pin low, the third rising clock edge after reset release loads the decoded strap values into each port's register 0 (bit 13 = speed, bit 12 = auto-negotiation enable, bit 8 = duplex) and register 19 (bit 2 = fiber). All other bits reset to 0.
- R3: In management control, after the preload, changes on the strap pins have no effect on any register or output.
- R4: In management control, a write replaces all 16 bits of the addressed register of the selected port. The outputs `port_speed`, `port_an_en`, `port_duplex` and `port_fiber` always equal bits 0.13, 0.12, 0.8 and 19.2 of the matching port.
- R5: In manual control, management writes change no register.
- R6: In manual control, a pin change appears in the registers and outputs on the third rising edge after it is applied.
- R7: For a port whose fiber-select pin is low, the decode is: speed bit = speed pin (1 = 100 Mb/s), duplex bit = duplex pin (1 = full), auto-negotiation bit = auto-negotiation pin, fiber bit = 0.
- R8: For a port whose fiber-select pin is high, the decode is: speed bit = 1, auto-negotiation bit = 0, duplex bit = fiber duplex pin, fiber bit = 1. The global speed, duplex and auto-negotiation pins are ignored for that port.
- R9: A read request returns, one cycle later with `rd_valid` high, the register contents as they were at the request edge. `rd_valid` is low in every cycle that does not follow a request.
- R10: Only addresses 0–6 and 16–20 are implemented. A write to any other address is dropped, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_manual_pin | input | 1 | 1 = manual (pin) control, 0 = management control |
| an_en_pin | input | 1 | Global auto-negotiation enable strap |
| speed_pin | input | 1 | Global speed strap, 1 = 100 Mb/s |
| duplex_pin | input | 1 | Global duplex strap, 1 = full |
| fiber_fdx_pin | input | 1 | Duplex for ports in fiber mode, 1 = full |
| fiber_sel_pin | input | 4 | Per-port fiber select, bit p for port p |
| wr_en | input | 1 | Register write strobe |
| rd_req | input | 1 | Register read request |
| port_sel | input | 2 | Port index for the access |
| reg_addr | input | 5 | Register number |
| wr_data | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | 16 | Read data |
| port_speed | output | 4 | Per-port speed bit (0.13) |
| port_an_en | output | 4 | Per-port auto-negotiation bit (0.12) |
| port_duplex | output | 4 | Per-port duplex bit (0.8) |
| port_fiber | output | 4 | Per-port fiber bit (19.2) |

## Verification
The decode is driven with directed patterns: all ports twisted-pair at 100 Mb/s full duplex with auto-negotiation off, mixed fiber/twisted-pair masks, and every fiber port with the global pins opposite to the fiber values. These show whether the fiber override wins and whether the global pins leak into fiber ports. Random pin patterns in manual control check tracking latency and per-port independence. In management control the same random pin changes must leave the outputs frozen, which tells the two regimes apart. Random writes and reads over all 32 addresses separate implemented from unimplemented addresses, show that writes are blocked in manual mode, and show the full 16-bit storage of non-strap registers.

// File: rtl/phy_strap_pkg.sv
package phy_strap_pkg;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 5;
  localparam int NUM_SLOTS  = 12;
  localparam int SLOT_W     = 4;
  localparam int SYNC_DEPTH = 2;
  localparam int SPEED_BIT  = 13;
  localparam int AN_BIT     = 12;
  localparam int DUPLEX_BIT = 8;
  localparam int FIBER_BIT  = 2;
  localparam int CTRL_SLOT  = 0;   // register 0
  localparam int MODE_SLOT  = 10;  // register 19

  typedef struct packed {
    logic speed;
    logic an_en;
    logic duplex;
    logic fiber;
  } port_cfg_t;

  // Fiber select overrides the global twisted-pair straps
  function automatic port_cfg_t resolve_cfg(input logic an, input logic spd,
                                            input logic dpx, input logic fib,
                                            input logic fib_fdx);
    port_cfg_t c;
    if (fib) begin
      c.speed = 1'b1; c.an_en = 1'b0; c.duplex = fib_fdx; c.fiber = 1'b1;
    end else begin
      c.speed = spd;  c.an_en = an;   c.duplex = dpx;     c.fiber = 1'b0;
    end
    return c;
  endfunction

  function automatic logic addr_implemented(input logic [ADDR_W-1:0] a);
    return (a <= 5'd6) || ((a >= 5'd16) && (a <= 5'd20));
  endfunction

  function automatic logic [SLOT_W-1:0] addr_slot(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = (a <= 5'd6) ? a : (a - 5'd9);
    return t[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q_o = stage[STAGES-1];
endmodule

// File: rtl/strap_init.sv
module strap_init #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      if (load_o) done_o <= 1'b1;
    end
  end

  assign load_o = (cnt == LAST) && !done_o;

  // R2: the preload fires a single time per reset
  assert_preload_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !load_o));
  assert_load_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
endmodule

// File: rtl/strap_port_regs.sv
module strap_port_regs
  import phy_strap_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track_i,
  input  logic              load_i,
  input  logic              wr_ok_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  port_cfg_t         cfg_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [REG_W-1:0]  rd_word_o,
  output port_cfg_t         cfg_o
);
  logic [REG_W-1:0] regs [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) regs[i] <= '0;
    end else if (track_i || load_i) begin
      regs[CTRL_SLOT][SPEED_BIT]  <= cfg_i.speed;
      regs[CTRL_SLOT][AN_BIT]     <= cfg_i.an_en;
      regs[CTRL_SLOT][DUPLEX_BIT] <= cfg_i.duplex;
      regs[MODE_SLOT][FIBER_BIT]  <= cfg_i.fiber;
    end else if (wr_ok_i) begin
      regs[wr_slot_i] <= wr_data_i;
    end
  end

  assign rd_word_o    = regs[rd_slot_i];
  assign cfg_o.speed  = regs[CTRL_SLOT][SPEED_BIT];
  assign cfg_o.an_en  = regs[CTRL_SLOT][AN_BIT];
  assign cfg_o.duplex = regs[CTRL_SLOT][DUPLEX_BIT];
  assign cfg_o.fiber  = regs[MODE_SLOT][FIBER_BIT];

  // R8: under pin tracking a fiber port runs at 100 Mb/s with auto-negotiation off
  assert_fiber_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    track_i |=> (!cfg_o.fiber || (cfg_o.speed && !cfg_o.an_en)));

  // R5: registers without strap fields never move under manual control
  for (genvar s = 0; s < SLOTS; s++) begin : g_hold
    if (s != CTRL_SLOT && s != MODE_SLOT) begin : g_chk
      assert_manual_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        track_i |=> $stable(regs[s]));
    end
  end
endmodule

// File: rtl/phy_strap_ctrl.sv
module phy_strap_ctrl
  import phy_strap_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_manual_pin,
  input  logic                 an_en_pin,
  input  logic                 speed_pin,
  input  logic                 duplex_pin,
  input  logic                 fiber_fdx_pin,
  input  logic [NUM_PORTS-1:0] fiber_sel_pin,
  input  logic                 wr_en,
  input  logic                 rd_req,
  input  logic [PORT_W-1:0]    port_sel,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic                 rd_valid,
  output logic [REG_W-1:0]     rd_data,
  output logic [NUM_PORTS-1:0] port_speed,
  output logic [NUM_PORTS-1:0] port_an_en,
  output logic [NUM_PORTS-1:0] port_duplex,
  output logic [NUM_PORTS-1:0] port_fiber
);
  localparam int STRAP_W = NUM_PORTS + 5;

  logic [STRAP_W-1:0]   strap_q;
  logic                 manual_s, an_s, spd_s, dpx_s, fdx_s;
  logic [NUM_PORTS-1:0] fib_s;
  logic                 init_load, init_done;
  logic                 addr_ok;
  logic [SLOT_W-1:0]    slot;
  logic [REG_W-1:0]     word   [NUM_PORTS];
  port_cfg_t            cfg_in [NUM_PORTS];
  port_cfg_t            cfg_out[NUM_PORTS];

  strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d_i ({mode_manual_pin, an_en_pin, speed_pin, duplex_pin, fiber_fdx_pin, fiber_sel_pin}),
    .q_o (strap_q)
  );
  assign {manual_s, an_s, spd_s, dpx_s, fdx_s, fib_s} = strap_q;

  strap_init #(.SETTLE(SYNC_DEPTH)) u_init (
    .clk (clk),
    .rst_n (rst_n),
    .load_o (init_load),
    .done_o (init_done)
  );

  assign addr_ok = addr_implemented(reg_addr);
  assign slot    = addr_slot(reg_addr);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign cfg_in[p] = resolve_cfg(an_s, spd_s, dpx_s, fib_s[p], fdx_s);

    strap_port_regs u_regs (
      .clk (clk),
      .rst_n (rst_n),
      .track_i (manual_s),
      .load_i (init_load && !manual_s),
      .wr_ok_i (wr_en && addr_ok && init_done && !manual_s && (port_sel == PORT_W'(p))),
      .wr_slot_i (slot),
      .wr_data_i (wr_data),
      .cfg_i (cfg_in[p]),
      .rd_slot_i (slot),
      .rd_word_o (word[p]),
      .cfg_o (cfg_out[p])
    );

    assign port_speed[p]  = cfg_out[p].speed;
    assign port_an_en[p]  = cfg_out[p].an_en;
    assign port_duplex[p] = cfg_out[p].duplex;
    assign port_fiber[p]  = cfg_out[p].fiber;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= addr_ok ? word[port_sel] : '0;
    end
  end

  // R9: one-cycle read latency, no stray valid
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_no_stray_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R10: unimplemented addresses read as zero
  assert_unimpl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !addr_ok) |=> (rd_data == '0));
  // R3: after the preload in management control, only writes move the outputs
  assert_mgmt_pins_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !manual_s && !wr_en) |=>
      ($stable(port_speed) && $stable(port_an_en) && $stable(port_duplex) && $stable(port_fiber)));
endmodule

// File: tb/tb_phy_strap_ctrl.sv
`timescale 1ns/1ps
module tb_phy_strap_ctrl;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_manual_pin = 1'b0, an_en_pin = 1'b0, speed_pin = 1'b0;
  logic duplex_pin = 1'b0, fiber_fdx_pin = 1'b0;
  logic [NP-1:0] fiber_sel_pin = '0;
  logic wr_en = 1'b0, rd_req = 1'b0;
  logic [1:0] port_sel = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic rd_valid;
  logic [15:0] rd_data;
  logic [NP-1:0] port_speed, port_an_en, port_duplex, port_fiber;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mdl [NP][32];

  always #2.5 clk = ~clk;

  phy_strap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_manual_pin(mode_manual_pin), .an_en_pin(an_en_pin),
    .speed_pin(speed_pin), .duplex_pin(duplex_pin), .fiber_fdx_pin(fiber_fdx_pin),
    .fiber_sel_pin(fiber_sel_pin), .wr_en(wr_en), .rd_req(rd_req), .port_sel(port_sel),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .port_speed(port_speed), .port_an_en(port_an_en), .port_duplex(port_duplex),
    .port_fiber(port_fiber)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit impl(input logic [4:0] a);
    return (a <= 5'd6) || (a >= 5'd16 && a <= 5'd20);
  endfunction

  // Strap decode from R7/R8, applied to model registers 0 and 19
  function automatic void apply_straps();
    for (int p = 0; p < NP; p++) begin
      if (fiber_sel_pin[p]) begin
        mdl[p][0][13] = 1'b1; mdl[p][0][12] = 1'b0;
        mdl[p][0][8]  = fiber_fdx_pin; mdl[p][19][2] = 1'b1;
      end else begin
        mdl[p][0][13] = speed_pin; mdl[p][0][12] = an_en_pin;
        mdl[p][0][8]  = duplex_pin; mdl[p][19][2] = 1'b0;
      end
    end
  endfunction

  function automatic void clear_model();
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 32; a++) mdl[p][a] = '0;
  endfunction

  task automatic check_outs(input string req);
    logic [NP-1:0] es, ea, ed, ef;
    for (int p = 0; p < NP; p++) begin
      es[p] = mdl[p][0][13]; ea[p] = mdl[p][0][12];
      ed[p] = mdl[p][0][8];  ef[p] = mdl[p][19][2];
    end
    check(port_speed == es,  {req, " speed"},  32'(port_speed),  32'(es));
    check(port_an_en == ea,  {req, " an_en"},  32'(port_an_en),  32'(ea));
    check(port_duplex == ed, {req, " duplex"}, 32'(port_duplex), 32'(ed));
    check(port_fiber == ef,  {req, " fiber"},  32'(port_fiber),  32'(ef));
  endtask

  task automatic do_write(input logic [1:0] p, input logic [4:0] a, input logic [15:0] d);
    port_sel = p; reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] p, input logic [4:0] a, input string req);
    logic [15:0] exp;
    port_sel = p; reg_addr = a; rd_req = 1'b1;
    exp = impl(a) ? mdl[p][a] : 16'h0;
    @(negedge clk);
    rd_req = 1'b0;
    check(rd_valid === 1'b1, {req, " rd_valid"}, 32'(rd_valid), 32'd1);
    check(rd_data === exp, req, 32'(rd_data), 32'(exp));
    @(negedge clk);
    check(rd_valid === 1'b0, "R9 valid drops", 32'(rd_valid), 32'd0);
  endtask

  task automatic set_pins(input logic [8:0] v);
    {an_en_pin, speed_pin, duplex_pin, fiber_fdx_pin, fiber_sel_pin} = v;
  endtask

  task automatic do_reset(input logic manual);
    mode_manual_pin = manual;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 32'd0);
    check({port_speed, port_an_en, port_duplex, port_fiber} === '0, "R1 outputs",
          32'({port_speed, port_an_en, port_duplex, port_fiber}), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    clear_model();
    apply_straps();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // Management control: mixed fiber mask, R2 preload with R7/R8 decode
    set_pins({1'b1, 1'b0, 1'b0, 1'b1, 4'b0101});
    do_reset(1'b0);
    check_outs("R2 preload");
    check_outs("R8 fiber ports 0,2 / R7 tp ports 1,3");
    // R3: pin changes ignored after preload
    for (int i = 0; i < 6; i++) begin
      set_pins(9'($urandom));
      repeat (5) @(negedge clk);
      check_outs("R3 pins ignored");
    end
    // R10 directed: unimplemented writes dropped, reads zero
    do_write(2'd1, 5'd10, 16'hBEEF);
    do_read(2'd1, 5'd10, "R10 unimpl read");
    do_write(2'd3, 5'd20, 16'h1234); mdl[3][20] = 16'h1234;
    do_read(2'd3, 5'd20, "R10 edge addr 20");
    do_write(2'd2, 5'd0, 16'hFFFF); mdl[2][0] = 16'hFFFF;
    check_outs("R4 write reg0 all ones");
    // Random management traffic
    for (int i = 0; i < 300; i++) begin
      logic [1:0] p; logic [4:0] a; logic [15:0] d;
      p = 2'($urandom); a = 5'($urandom); d = 16'($urandom);
      if ($urandom % 2 == 0) begin
        do_write(p, a, d);
        if (impl(a)) mdl[p][a] = d;
        check_outs("R4 outputs follow regs");
      end else begin
        do_read(p, a, impl(a) ? "R9 read data" : "R10 unimpl read");
      end
    end
    // Manual control
    set_pins({1'b0, 1'b1, 1'b1, 1'b0, 4'b0000});
    do_reset(1'b1);
    check_outs("R7 tp 100 full an off");
    set_pins({1'b1, 1'b0, 1'b0, 1'b1, 4'b1111});
    repeat (4) @(negedge clk); apply_straps();
    check_outs("R8 all fiber global pins opposite");
    // R6 latency: not yet visible after two edges, visible after three
    set_pins({1'b1, 1'b1, 1'b1, 1'b0, 4'b0000});
    @(negedge clk); @(negedge clk);
    check(port_fiber === 4'hF, "R6 not before third edge", 32'(port_fiber), 32'hF);
    @(negedge clk);
    apply_straps();
    check_outs("R6 third edge");
    for (int i = 0; i < 60; i++) begin
      logic [1:0] p; logic [4:0] a;
      set_pins(9'($urandom));
      repeat (4) @(negedge clk);
      apply_straps();
      check_outs("R6 tracking");
      p = 2'($urandom); a = 5'($urandom);
      if (i % 3 == 0) a = (i % 2 == 0) ? 5'd0 : 5'd4;
      do_write(p, a, 16'($urandom));
      do_read(p, a, "R5 write ignored");
      check_outs("R5 outputs unchanged");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule